// File: doc/BRIEF.md
# Dual Banked Stack Pointer Unit

This block holds two stack pointers, one for user state and one for supervisor state, behind a single architectural register number (register 7). A mode bit held in the block picks which of the two is visible. Reads and writes of register 7 reach only the visible pointer. The other pointer cannot be reached through that register.

Stack commands turn into single memory transfers on a request/done port. Push and subroutine call move the pointer down first and then write at the new address. Pop and return read at the current address and then move the pointer up. An exception entry always uses the supervisor pointer, whatever the current mode. It writes the program counter and then the status word, and after that it switches the mode bit to supervisor. A pointer changes only when the memory side has acknowledged the transfer.

Top module: `stk_ptr_bank`

## Requirements
- R1: A register 7 read (cmd_op 6) returns the supervisor pointer when `super_mode` is 1 and the user pointer when it is 0, on `rd_data` with `rd_valid` high in the cycle after acceptance.
- R2: A register 7 write (cmd_op 7) loads `cmd_data` into the visible pointer only; the hidden pointer keeps its value.
- R3: A push (cmd_op 1) computes the new address as the visible pointer minus the step. It issues a write of `cmd_data` to that address, and once the write is acknowledged the pointer takes that address.
- R4: A pop (cmd_op 2) reads at the visible pointer, returns `mem_rdata` on `rd_data` with `rd_valid`, and once the read is acknowledged it adds the step to the pointer.
- R5: `cmd_size` 0 is byte, 1 is word, and 2 or 3 is long, and `mem_size` uses 0, 1 and 2 for the same sizes. The pointer step is 2 for byte and word and 4 for long, so a byte transfer keeps the pointer even.
- R6: A call (cmd_op 3) pushes `cmd_data` as a long on the visible stack. A return (cmd_op 4) pops a long from the visible stack.
- R7: An exception (cmd_op 5) in either mode writes `cmd_data` as a long at supervisor pointer minus 4, then writes `cmd_sr` as a word at supervisor pointer minus 6. The supervisor pointer ends 6 lower, the user pointer is unchanged, and `super_mode` becomes 1 after the second write.
- R8: While `mem_done` is low, `mem_req` stays high and the address, data, size and direction stay stable, and neither pointer changes.
- R9: A command is taken only when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low while a transfer is in flight. cmd_op 0 loads `super_mode` from `cmd_data[0]`.
- R10: After reset the user pointer is `USP_INIT`, the supervisor pointer is `SSP_INIT`, `super_mode` is 1, `mem_req` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R1–R9) |
| cmd_size | input | 2 | Operand size for push and pop |
| cmd_data | input | W | Push data, program counter, or register 7 / mode write value |
| cmd_sr | input | 16 | Status word stacked on exception |
| cmd_ready | output | 1 | Block is idle and takes a command |
| super_mode | output | 1 | Mode bit, 1 = supervisor |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Transfer size |
| mem_addr | output | W | Transfer address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with mem_done |
| mem_done | input | 1 | Transfer acknowledge |
| rd_valid | output | 1 | Result on rd_data is valid |
| rd_data | output | W | Pop or register 7 read result |
| usp | output | W | User stack pointer |
| ssp | output | W | Supervisor stack pointer |

## Verification
On every cycle the assertions check that the request and its payload are held until done and that neither pointer moves before done. They also check that an acknowledged write leaves a pointer equal to its address, that a pop moves a pointer up by 2 or 4, and that an exception starts on the supervisor stack 4 bytes down. Only the bench scenarios can show the rest. These cover the order and content of the two exception writes, the hidden pointer surviving writes, calls and exceptions in the other mode, the byte step of 2, and the data returned by pops matching what was pushed earlier.

// File: rtl/stk_ptr_bank.sv
module stk_ptr_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] USP_INIT = 'h2000,
  parameter logic [W-1:0] SSP_INIT = 'h1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [1:0]   cmd_size,
  input  logic [W-1:0] cmd_data,
  input  logic [15:0]  cmd_sr,
  output logic         cmd_ready,
  output logic         super_mode,
  output logic         mem_req,
  output logic         mem_we,
  output logic [1:0]   mem_size,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_done,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] usp,
  output logic [W-1:0] ssp
);
  localparam logic [1:0] SZ_W = 2'd1, SZ_L = 2'd2;
  localparam logic [2:0] OP_MODE = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2, OP_CALL = 3'd3,
                         OP_RET = 3'd4, OP_EXC = 3'd5, OP_RD = 3'd6, OP_WR = 3'd7;

  typedef enum logic [1:0] {IDLE, XFER, EXC_PC} st_t;
  st_t st;

  logic         sel_q, exc_q;
  logic [W-1:0] step_q;
  logic [15:0]  sr_q;

  wire          accept = cmd_valid && cmd_ready;
  wire [W-1:0]  cur    = super_mode ? ssp : usp;
  wire          is_sub = (cmd_op == OP_CALL) || (cmd_op == OP_RET);
  wire [1:0]    eff_sz = (is_sub || cmd_size[1]) ? SZ_L : cmd_size;
  wire [W-1:0]  step   = (eff_sz == SZ_L) ? W'(4) : W'(2);
  wire [W-1:0]  nxt    = mem_we ? mem_addr : mem_addr + step_q;

  assign cmd_ready = (st == IDLE);
  assign mem_req   = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      usp <= USP_INIT;
      ssp <= SSP_INIT;
      super_mode <= 1'b1;
      rd_valid <= 1'b0;
      rd_data <= '0;
      mem_we <= 1'b0;
      mem_size <= '0;
      mem_addr <= '0;
      mem_wdata <= '0;
      sel_q <= 1'b0;
      exc_q <= 1'b0;
      step_q <= '0;
      sr_q <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          case (cmd_op)
            OP_MODE: super_mode <= cmd_data[0];
            OP_RD: begin
              rd_valid <= 1'b1;
              rd_data <= cur;
            end
            OP_WR: if (super_mode) ssp <= cmd_data; else usp <= cmd_data;
            OP_PUSH, OP_CALL: begin
              st <= XFER;
              mem_we <= 1'b1;
              mem_addr <= cur - step;
              mem_size <= eff_sz;
              mem_wdata <= cmd_data;
              sel_q <= super_mode;
              step_q <= step;
            end
            OP_POP, OP_RET: begin
              st <= XFER;
              mem_we <= 1'b0;
              mem_addr <= cur;
              mem_size <= eff_sz;
              mem_wdata <= '0;
              sel_q <= super_mode;
              step_q <= step;
            end
            default: begin
              st <= EXC_PC;
              mem_we <= 1'b1;
              mem_addr <= ssp - W'(4);
              mem_size <= SZ_L;
              mem_wdata <= cmd_data;
              sel_q <= 1'b1;
              sr_q <= cmd_sr;
            end
          endcase
        end
        EXC_PC: if (mem_done) begin
          ssp <= mem_addr;
          mem_addr <= mem_addr - W'(2);
          mem_size <= SZ_W;
          mem_wdata <= W'(sr_q);
          exc_q <= 1'b1;
          st <= XFER;
        end
        default: if (mem_done) begin
          st <= IDLE;
          exc_q <= 1'b0;
          if (exc_q) super_mode <= 1'b1;
          if (sel_q) ssp <= nxt; else usp <= nxt;
          if (!mem_we) begin
            rd_valid <= 1'b1;
            rd_data <= mem_rdata;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/stk_ptr_bank_chk.sv
module stk_ptr_bank_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic         cmd_ready,
  input logic         super_mode,
  input logic         mem_req,
  input logic         mem_we,
  input logic [1:0]   mem_size,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_done,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] usp,
  input logic [W-1:0] ssp
);
  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                             && $stable(mem_we) && $stable(mem_size));

  assert_no_early_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> $stable(usp) && $stable(ssp));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  assert_push_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_done |=> (usp == $past(mem_addr)) || (ssp == $past(mem_addr)));

  assert_pop_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_done |=>
      ((usp - $past(mem_addr)) == W'(2)) || ((usp - $past(mem_addr)) == W'(4)) ||
      ((ssp - $past(mem_addr)) == W'(2)) || ((ssp - $past(mem_addr)) == W'(4)));

  assert_exc_on_ssp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd5 |=>
      mem_req && mem_we && mem_size == 2'd2 && mem_addr == ssp - W'(4));

  assert_rd7_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd6 |=>
      rd_valid && rd_data == (super_mode ? ssp : usp));
endmodule

bind stk_ptr_bank stk_ptr_bank_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
  .super_mode(super_mode), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done), .rd_valid(rd_valid),
  .rd_data(rd_data), .usp(usp), .ssp(ssp));

// File: tb/stk_ptr_bank_tb_top.sv
module stk_ptr_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_size = 0;
  logic [31:0] cmd_data = 0;
  logic [15:0] cmd_sr = 0;
  logic cmd_ready, super_mode, mem_req, mem_we, rd_valid;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata, rd_data, usp, ssp;
  logic [31:0] mem_rdata = 0;
  logic mem_done = 0;

  stk_ptr_bank dut_i (.*);

  always #2 clk = ~clk;

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; logic [1:0] size; string tag; } xact_t;
  xact_t exp_q[$];
  logic [31:0] mem_model [logic [31:0]];
  int tests = 0, fails = 0, lat = 0;
  bit done_flag = 0;
  logic [31:0] m_usp = 32'h2000, m_ssp = 32'h1000;
  bit m_mode = 1;
  bit last_rv;
  logic [31:0] last_rd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: memory responder and scoreboard
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      xact_t e;
      logic [31:0] bu, bs;
      bu = usp; bs = ssp;
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected transfer", mem_addr, 0);
      end else begin
        e = exp_q.pop_front();
        check(mem_we == e.we && mem_addr == e.addr && mem_size == e.size &&
              (!e.we || mem_wdata == e.data), e.tag, mem_addr, e.addr);
      end
      if (mem_we) mem_model[mem_addr] = mem_wdata;
      repeat (lat) @(negedge clk);
      check(usp == bu && ssp == bs && mem_req, "R8 pointer held before done", usp ^ ssp, bu ^ bs);
      mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : (mem_addr ^ 32'hA5A5_0000);
      mem_done = 1;
      @(negedge clk);
      mem_done = 0;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d, input logic [15:0] sr);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_size = sz; cmd_data = d; cmd_sr = sr; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (op >= 3'd1 && op <= 3'd5) check(!cmd_ready && mem_req, "R9 busy during transfer", {31'b0, cmd_ready}, 0);
    while (!cmd_ready) @(negedge clk);
    last_rv = rd_valid; last_rd = rd_data;
  endtask

  task automatic check_ptrs(input string tag);
    check(usp == m_usp, {tag, " usp"}, usp, m_usp);
    check(ssp == m_ssp, {tag, " ssp"}, ssp, m_ssp);
    check(super_mode == m_mode, {tag, " mode"}, {31'b0, super_mode}, {31'b0, m_mode});
  endtask

  function automatic logic [31:0] stepf(input logic [1:0] sz);
    return (sz >= 2) ? 32'd4 : 32'd2;
  endfunction

  task automatic do_push(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d, input string tag);
    logic [31:0] a;
    logic [1:0] es;
    es = (op == 3'd3 || sz == 3) ? 2'd2 : sz;
    a = (m_mode ? m_ssp : m_usp) - stepf(es);
    exp_q.push_back('{1'b1, a, d, es, {tag, " write"}});
    issue(op, sz, d, 0);
    if (m_mode) m_ssp = a; else m_usp = a;
    check_ptrs(tag);
  endtask

  task automatic do_pop(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] expd, input string tag);
    logic [31:0] a;
    logic [1:0] es;
    es = (op == 3'd4 || sz == 3) ? 2'd2 : sz;
    a = m_mode ? m_ssp : m_usp;
    exp_q.push_back('{1'b0, a, 32'h0, es, {tag, " read"}});
    issue(op, sz, 0, 0);
    if (m_mode) m_ssp = a + stepf(es); else m_usp = a + stepf(es);
    check(last_rv && last_rd == expd, {tag, " data"}, last_rd, expd);
    check_ptrs(tag);
  endtask

  task automatic do_exc(input logic [31:0] pc, input logic [15:0] sr);
    exp_q.push_back('{1'b1, m_ssp - 4, pc, 2'd2, "R7 pc write"});
    exp_q.push_back('{1'b1, m_ssp - 6, {16'h0, sr}, 2'd1, "R7 sr write"});
    issue(3'd5, 0, pc, sr);
    m_ssp = m_ssp - 6; m_mode = 1;
    check_ptrs("R7 exception");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_ptrs("R10 reset");
    check(!mem_req && cmd_ready, "R10 idle after reset", {30'b0, mem_req, cmd_ready}, 32'd1);

    issue(3'd6, 0, 0, 0);
    check(last_rv && last_rd == 32'h1000, "R1 read in supervisor", last_rd, 32'h1000);
    issue(3'd7, 0, 32'h1800, 0); m_ssp = 32'h1800;
    check_ptrs("R2 write in supervisor");
    issue(3'd0, 0, 0, 0); m_mode = 0;
    check_ptrs("R9 mode write");
    issue(3'd6, 0, 0, 0);
    check(last_rv && last_rd == 32'h2000, "R1 read in user", last_rd, 32'h2000);
    issue(3'd7, 0, 32'h3000, 0); m_usp = 32'h3000;
    check_ptrs("R2 write in user");

    lat = 2;
    do_push(3'd1, 2'd2, 32'hCAFE_BABE, "R3 long push");
    do_push(3'd1, 2'd0, 32'h0000_005A, "R5 byte push");
    lat = 0;
    do_push(3'd1, 2'd1, 32'h0000_1234, "R5 word push");
    do_pop(3'd2, 2'd1, 32'h0000_1234, "R4 word pop");
    lat = 3;
    do_pop(3'd2, 2'd0, 32'h0000_005A, "R5 byte pop");
    do_push(3'd3, 2'd0, 32'h0000_0400, "R6 call user");
    lat = 1;
    do_pop(3'd4, 2'd0, 32'h0000_0400, "R6 return user");
    do_pop(3'd2, 2'd3, 32'hCAFE_BABE, "R5 size3 long pop");
    do_exc(32'h0000_0500, 16'h0700);
    do_push(3'd3, 2'd1, 32'h0000_0600, "R6 call supervisor");
    do_pop(3'd2, 2'd2, 32'h0000_0600, "R4 long pop supervisor");
    lat = 2;
    do_exc(32'h0000_0700, 16'h2700);
    do_pop(3'd2, 2'd1, 32'h0000_2700, "R7 stacked sr");
    do_pop(3'd2, 2'd2, 32'h0000_0700, "R7 stacked pc");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all transfers seen", exp_q.size(), 0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule